// File: doc/BRIEF.md
# Erase Command Sequence Checker

This block sits on the device side of a managed flash card, after command decoding. It watches the three-step erase protocol: set the start group, set the end group, then trigger the erase. It checks each address against the device capacity and the erase-group alignment. For every decoded command it returns a 32-bit card-status word, one cycle later. While an accepted erase runs, it drives a busy flag for a programmable number of cycles.

Errors are reported late on purpose. A misaligned start address is accepted quietly and flagged only when the end address arrives. An address beyond the device silently drops the whole sequence, so a later trigger sees a sequence error. Status polling is allowed at any time and disturbs nothing.

Top module: `erase_seq_ctrl`

## Requirements
- R1: Every cycle with `cmd_valid` high produces `rsp_valid` high in the next cycle, carrying the status for that command. A cycle without a command gives `rsp_valid` low in the next cycle.
- R2: Start (index 35, aligned, in range), then end (index 36, not below start, in range), then trigger (index 38) gives responses with no error bits. Busy is high from the trigger's response cycle for `erase_cycles` cycles (one cycle when `erase_cycles` is 0), then falls.
- R3: An end-address command (36) with no start held returns status bit 28 (sequence error), and no sequence is entered.
- R4: A start address whose low `GRP_SHIFT` bits are not all zero is accepted without bit 27 in its own response. The next end-address command returns bit 27 (erase parameter) and drops the sequence.
- R5: An end address numerically lower than the held start address returns bit 27 and drops the sequence.
- R6: A start or end address above `DEV_LAST` returns bit 31 (address out of range) and drops the sequence. A later trigger then returns bit 28 and starts no erase.
- R7: A trigger (38) without both addresses held returns bit 28 and busy stays low.
- R8: Any index other than 13, 35, 36 or 38 received while a sequence is held returns bit 13 (erase reset) and drops the sequence. The same command with no sequence held returns no bit 13.
- R9: Bits 27 and 13 are clear-on-read. Each appears in exactly one response, and the next response has it clear.
- R10: A status query (index 13) changes neither the held sequence nor the busy countdown.
- R11: Status bits 12:9 hold 7 (programming) when the command was received while busy, and 4 (transfer) otherwise.
- R12: While busy, every command other than 13 leaves the sequence unchanged and returns no error bits.
- R13: A repeated start command replaces the held start, and a repeated end command replaces the held end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| erase_cycles | input | CNT_W | Erase duration in cycles (0 is treated as 1) |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument (erase-group address) |
| rsp_valid | output | 1 | Response strobe, one cycle after the command |
| rsp_status | output | 32 | Card-status word for the response |
| busy | output | 1 | Erase in progress |

## Verification
The bench builds the block with `DEV_LAST` = 0x0FFF and `GRP_SHIFT` = 4. With these values, out-of-range arguments (0x1000, 0x2000) and misaligned ones (0x105) are short literals next to aligned ones such as 0x100. `CNT_W` = 8 keeps erase windows of 0, 3, 5 and 30 cycles short. The 30-cycle window is long enough to issue a status query, a foreign command, an end address and a start address while busy is still high. The zero setting reaches the one-cycle minimum.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  localparam int unsigned BIT_OOR   = 31;
  localparam int unsigned BIT_SEQ   = 28;
  localparam int unsigned BIT_PARAM = 27;
  localparam int unsigned BIT_ERST  = 13;
  localparam int unsigned ST_LSB    = 9;

  localparam logic [5:0] CMD_STATUS    = 6'd13;
  localparam logic [5:0] CMD_SET_START = 6'd35;
  localparam logic [5:0] CMD_SET_END   = 6'd36;
  localparam logic [5:0] CMD_ERASE     = 6'd38;

  localparam logic [3:0] DEV_TRAN = 4'd4;
  localparam logic [3:0] DEV_PRG  = 4'd7;

  typedef enum logic [1:0] {
    SEQ_IDLE       = 2'd0,
    SEQ_HAVE_START = 2'd1,
    SEQ_HAVE_END   = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic oor;
    logic seq_err;
    logic param;
    logic erase_rst;
  } err_flags_t;

  // Address above the last valid location of the device.
  function automatic logic addr_beyond(logic [31:0] addr, logic [31:0] last);
    return addr > last;
  endfunction

  // Any of the low group-offset bits set.
  function automatic logic addr_unaligned(logic [31:0] addr, int unsigned shift);
    logic [31:0] mask;
    mask = (32'h1 << shift) - 32'h1;
    return |(addr & mask);
  endfunction

  function automatic logic [31:0] pack_status(err_flags_t f, logic prg);
    logic [31:0] s;
    s = '0;
    s[BIT_OOR]   = f.oor;
    s[BIT_SEQ]   = f.seq_err;
    s[BIT_PARAM] = f.param;
    s[BIT_ERST]  = f.erase_rst;
    s[ST_LSB +: 4] = prg ? DEV_PRG : DEV_TRAN;
    return s;
  endfunction

endpackage

// File: rtl/erase_addr_check.sv
module erase_addr_check #(
  parameter logic [31:0] DEV_LAST  = 32'h000F_FFFF,
  parameter int unsigned GRP_SHIFT = 10
) (
  input  logic [31:0] arg,
  input  logic [31:0] start_q,
  output logic        beyond,
  output logic        unaligned,
  output logic        below_start
);
  import erase_seq_pkg::*;

  always_comb begin
    beyond      = addr_beyond(arg, DEV_LAST);
    unaligned   = addr_unaligned(arg, GRP_SHIFT);
    below_start = arg < start_q;
  end
endmodule

// File: rtl/erase_timer.sv
module erase_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (load_val == '0) ? ONE : load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
  import erase_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic        busy,
  input  logic        beyond,
  input  logic        unaligned,
  input  logic        below_start,
  output logic [31:0] start_q,
  output seq_state_e  state_q,
  output err_flags_t  flags,
  output logic        erase_go
);
  seq_state_e  state_d;
  logic [31:0] start_d;
  logic        pend_q, pend_d;

  always_comb begin
    state_d  = state_q;
    start_d  = start_q;
    pend_d   = pend_q;
    flags    = '0;
    erase_go = 1'b0;
    if (cmd_valid && !busy) begin
      unique case (cmd_idx)
        CMD_SET_START: begin
          if (beyond) begin
            flags.oor = 1'b1;
            state_d   = SEQ_IDLE;
            pend_d    = 1'b0;
          end else begin
            state_d = SEQ_HAVE_START;
            start_d = cmd_arg;
            pend_d  = unaligned;
          end
        end
        CMD_SET_END: begin
          if (state_q == SEQ_IDLE) begin
            flags.seq_err = 1'b1;
          end else if (beyond) begin
            flags.oor = 1'b1;
            state_d   = SEQ_IDLE;
            pend_d    = 1'b0;
          end else if (pend_q || below_start) begin
            flags.param = 1'b1;
            state_d     = SEQ_IDLE;
            pend_d      = 1'b0;
          end else begin
            state_d = SEQ_HAVE_END;
          end
        end
        CMD_ERASE: begin
          if (state_q == SEQ_HAVE_END) begin
            erase_go = 1'b1;
          end else begin
            flags.seq_err = 1'b1;
          end
          state_d = SEQ_IDLE;
          pend_d  = 1'b0;
        end
        CMD_STATUS: begin
        end
        default: begin
          if (state_q != SEQ_IDLE) begin
            flags.erase_rst = 1'b1;
            state_d         = SEQ_IDLE;
            pend_d          = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      start_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
#(
  parameter logic [31:0] DEV_LAST  = 32'h000F_FFFF,
  parameter int unsigned GRP_SHIFT = 10,
  parameter int unsigned CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] erase_cycles,
  input  logic             cmd_valid,
  input  logic [5:0]       cmd_idx,
  input  logic [31:0]      cmd_arg,
  output logic             rsp_valid,
  output logic [31:0]      rsp_status,
  output logic             busy
);
  logic        beyond, unaligned, below_start;
  logic [31:0] start_q;
  seq_state_e  seq_state;
  err_flags_t  flags;
  logic        ev_erase_go;
  logic        ev_seq_abort;

  erase_addr_check #(.DEV_LAST(DEV_LAST), .GRP_SHIFT(GRP_SHIFT)) u_addr (
    .arg(cmd_arg), .start_q(start_q),
    .beyond(beyond), .unaligned(unaligned), .below_start(below_start)
  );

  erase_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
    .cmd_arg(cmd_arg), .busy(busy), .beyond(beyond), .unaligned(unaligned),
    .below_start(below_start), .start_q(start_q), .state_q(seq_state),
    .flags(flags), .erase_go(ev_erase_go)
  );

  erase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(ev_erase_go),
    .load_val(erase_cycles), .busy(busy)
  );

  assign ev_seq_abort = flags.erase_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      if (cmd_valid) begin
        rsp_status <= pack_status(flags, busy);
      end
    end
  end
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk
  import erase_seq_pkg::*;
#(
  parameter logic [31:0] DEV_LAST = 32'h000F_FFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [5:0]  cmd_idx,
  input logic [31:0] cmd_arg,
  input logic        rsp_valid,
  input logic [31:0] rsp_status,
  input logic        busy,
  input seq_state_e  seq_state,
  input logic        ev_erase_go,
  input logic        ev_seq_abort
);
  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);
  p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);
  p_busy_on_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_erase_go |=> busy);
  p_early_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_idx == CMD_SET_END && seq_state == SEQ_IDLE)
    |=> (rsp_status[BIT_SEQ] && seq_state == SEQ_IDLE));
  p_no_param_on_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_idx == CMD_SET_START) |=> !rsp_status[BIT_PARAM]);
  p_oor_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_arg > DEV_LAST &&
     (cmd_idx == CMD_SET_START || (cmd_idx == CMD_SET_END && seq_state != SEQ_IDLE)))
    |=> (rsp_status[BIT_OOR] && seq_state == SEQ_IDLE));
  p_early_trigger_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_idx == CMD_ERASE && seq_state != SEQ_HAVE_END)
    |=> (rsp_status[BIT_SEQ] && !busy));
  p_abort_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_abort |=> (rsp_status[BIT_ERST] && seq_state == SEQ_IDLE));
  p_query_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_idx == CMD_STATUS) |=> $stable(seq_state));
  p_prg_field_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> (rsp_status[ST_LSB +: 4] == DEV_PRG));
  p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> ($stable(seq_state) &&
      !rsp_status[BIT_OOR] && !rsp_status[BIT_SEQ] &&
      !rsp_status[BIT_PARAM] && !rsp_status[BIT_ERST]));
endmodule

bind erase_seq_ctrl erase_seq_chk #(.DEV_LAST(DEV_LAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
  .cmd_arg(cmd_arg), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .busy(busy), .seq_state(seq_state), .ev_erase_go(ev_erase_go),
  .ev_seq_abort(ev_seq_abort)
);

// File: tb/erase_seq_ctrl_tb.sv
module erase_seq_ctrl_tb;
  localparam int unsigned CNT_W = 8;

  localparam logic [31:0] TRAN  = 32'h0000_0800;
  localparam logic [31:0] PRG   = 32'h0000_0E00;
  localparam logic [31:0] OOR   = 32'h8000_0000;
  localparam logic [31:0] SEQ   = 32'h1000_0000;
  localparam logic [31:0] PARAM = 32'h0800_0000;
  localparam logic [31:0] ERST  = 32'h0000_2000;

  // {requirement number, command index, argument, expected status}
  localparam int NV = 19;
  localparam logic [77:0] VEC [NV] = '{
    {8'd3,  6'd36, 32'h0000_0200, SEQ | TRAN},   // R3 end without start
    {8'd13, 6'd35, 32'h0000_0100, TRAN},         // R13 start
    {8'd13, 6'd35, 32'h0000_0200, TRAN},         // R13 start replaced
    {8'd5,  6'd36, 32'h0000_0100, PARAM | TRAN}, // R5 end below start
    {8'd7,  6'd38, 32'h0000_0000, SEQ | TRAN},   // R7 trigger after drop
    {8'd4,  6'd35, 32'h0000_0105, TRAN},         // R4 misaligned, silent
    {8'd10, 6'd13, 32'h0000_0000, TRAN},         // R10 query, no flag yet
    {8'd4,  6'd36, 32'h0000_0300, PARAM | TRAN}, // R4 deferred flag
    {8'd9,  6'd13, 32'h0000_0000, TRAN},         // R9 flag cleared
    {8'd6,  6'd35, 32'h0000_0100, TRAN},         // R6 setup
    {8'd6,  6'd36, 32'h0000_1000, OOR | TRAN},   // R6 end out of range
    {8'd6,  6'd38, 32'h0000_0000, SEQ | TRAN},   // R6 trigger after drop
    {8'd8,  6'd35, 32'h0000_0100, TRAN},         // R8 setup
    {8'd8,  6'd17, 32'h0000_0000, ERST | TRAN},  // R8 foreign command
    {8'd9,  6'd13, 32'h0000_0000, TRAN},         // R9 reset bit cleared
    {8'd8,  6'd17, 32'h0000_0000, TRAN},         // R8 foreign while idle
    {8'd7,  6'd38, 32'h0000_0000, SEQ | TRAN},   // R7 trigger while idle
    {8'd6,  6'd35, 32'h0000_2000, OOR | TRAN},   // R6 start out of range
    {8'd6,  6'd36, 32'h0000_0200, SEQ | TRAN}    // R6 nothing held
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] erase_cycles = 8'd5;
  logic             cmd_valid = 1'b0;
  logic [5:0]       cmd_idx = '0;
  logic [31:0]      cmd_arg = '0;
  logic             rsp_valid;
  logic [31:0]      rsp_status;
  logic             busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  erase_seq_ctrl #(.DEV_LAST(32'h0000_0FFF), .GRP_SHIFT(4), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .erase_cycles(erase_cycles), .cmd_valid(cmd_valid),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge where the response is visible.
  task automatic issue(input logic [5:0] idx, input logic [31:0] arg);
    cmd_valid = 1'b1;
    cmd_idx   = idx;
    cmd_arg   = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R2 reset busy", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 no command no response", {31'd0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][69:64], VEC[i][63:32]);
      chk($sformatf("R%0d vector %0d valid", VEC[i][77:70], i), {31'd0, rsp_valid}, 32'd1);
      chk($sformatf("R%0d vector %0d status", VEC[i][77:70], i), rsp_status, VEC[i][31:0]);
    end

    // R2 and R13: full sequence with a replaced end, 5-cycle erase
    issue(6'd35, 32'h100); chk("R2 start", rsp_status, TRAN);
    issue(6'd36, 32'h200); chk("R2 end", rsp_status, TRAN);
    issue(6'd36, 32'h300); chk("R13 end replaced", rsp_status, TRAN);
    issue(6'd38, 32'h0);   chk("R2 trigger", rsp_status, TRAN);
    chk("R2 busy on trigger response", {31'd0, busy}, 32'd1);
    n = 1;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (!busy) break;
      n++;
    end
    chk("R2 busy length", n, 32'd5);

    // R2 zero duration gives one busy cycle
    erase_cycles = 8'd0;
    issue(6'd35, 32'h100);
    issue(6'd36, 32'h100);
    issue(6'd38, 32'h0);
    chk("R2 zero-length busy on", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk("R2 zero-length busy off", {31'd0, busy}, 32'd0);

    // R10, R11, R12: commands during a long erase
    erase_cycles = 8'd30;
    issue(6'd35, 32'h100);
    issue(6'd36, 32'h200);
    issue(6'd38, 32'h0);
    issue(6'd13, 32'h0);
    chk("R11 query while busy", rsp_status, PRG);
    chk("R10 busy kept after query", {31'd0, busy}, 32'd1);
    issue(6'd17, 32'h0);
    chk("R12 foreign while busy", rsp_status, PRG);
    issue(6'd36, 32'h400);
    chk("R12 end while busy", rsp_status, PRG);
    issue(6'd35, 32'h100);
    chk("R12 start while busy", rsp_status, PRG);
    wait_idle();
    chk("R2 busy ends", {31'd0, busy}, 32'd0);
    issue(6'd36, 32'h200);
    chk("R12 start during busy not held", rsp_status, SEQ | TRAN);

    // R10: query mid-sequence keeps the sequence
    erase_cycles = 8'd3;
    issue(6'd35, 32'h100);
    issue(6'd13, 32'h0);   chk("R10 query mid-sequence", rsp_status, TRAN);
    issue(6'd36, 32'h200); chk("R10 end after query", rsp_status, TRAN);
    issue(6'd13, 32'h0);
    issue(6'd38, 32'h0);   chk("R10 trigger after query", rsp_status, TRAN);
    chk("R10 erase started", {31'd0, busy}, 32'd1);
    wait_idle();

    // R7: trigger with only a start held
    issue(6'd35, 32'h100);
    issue(6'd38, 32'h0);
    chk("R7 trigger with start only", rsp_status, SEQ | TRAN);
    chk("R7 no busy", {31'd0, busy}, 32'd0);

    // Reset drops a held sequence
    issue(6'd35, 32'h100);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    issue(6'd36, 32'h200);
    chk("R3 end after reset", rsp_status, SEQ | TRAN);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule